// File: doc/BRIEF.md
# Camera Flash and Shutter Timing Controller

This block drives three camera control lines: shutter, strobe and pre-strobe. Each line belongs to its own channel. Software arms a channel by writing its arm bit. The channel first counts a programmed number of frame-start edges on a trigger line chosen from four inputs. It then waits a programmed number of count ticks and holds its line asserted for a programmed number of ticks. After that it drops its arm bit by itself, so each arm gives one pulse.

A shared prescaler divides the master clock to make the count tick. A divisor of zero stops the tick, and every delay and pulse counter holds its value until the tick comes back. The shutter line has its own polarity bit. The strobe and pre-strobe lines share one polarity bit. The block has no data stream, so there is no valid/ready handshake. The configuration port is a plain single-cycle write strobe that is always accepted.

Configuration map (word address, field bits):
- Address 0, control: divisor [8:0], trigger select [10:9], shutter polarity [11], flash polarity [12], global-reset direction [13], global-reset enable [14], arm shutter [15], arm strobe [16], arm pre-strobe [17].
- Per channel: addresses 4, 5, 6 for shutter; 8, 9, 10 for strobe; 12, 13, 14 for pre-strobe. Each group holds, in this order, the frame count [5:0], the delay [24:0] and the duration [23:0].

Top module: `flash_shutter_timer`

## Requirements
- R1: Trigger select value k (bits [10:9] of address 0) picks frame_start_i[k]. A frame edge is a rising edge of that line after two synchronizer flops. Edges on the other lines are ignored.
- R2: With divisor D > 0 a count tick occurs once every D clock cycles. With D = 0 no tick occurs, and delay and pulse counters hold.
- R3: A channel armed with frame count F > 0 waits for F frame edges before its delay starts. With F = 0 the delay starts in the cycle after arming.
- R4: With divisor 1, a write that arms a channel whose frame count is 0 and delay is L makes the line active at the (L+1)-th clock edge after the write edge when L > 0, and at the 2nd clock edge when L = 0.
- R5: A duration of N > 0 holds the line active for N ticks: exactly N cycles with divisor 1, and between (N-1)·D+1 and N·D cycles with divisor D.
- R6: Writing 1 to an arm bit sets it, and writing 0 leaves it unchanged. armed_o shows the bits as {pre-strobe, strobe, shutter}. A bit clears in the same clock edge that ends its pulse.
- R7: A line is active-high when its polarity bit is 1 and active-low when it is 0. The shutter uses bit [11]. Strobe and pre-strobe both use bit [12].
- R8: Writes to the global-reset enable and direction bits start no channel and change no output.
- R9: A line whose arm bit is clear sits at its inactive level.
- R10: A duration of 0 produces no active cycle, and the arm bit still clears after the delay.
- R11: Frame count, delay and duration are captured when a channel starts. Writes to them while it is armed apply only to the next arm.
- R12: Channels run independently. Several can be armed by one write, and each follows its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 4 | Candidate frame-start trigger lines |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 25 | Configuration write data |
| shutter_o | output | 1 | Shutter control line |
| strobe_o | output | 1 | Strobe control line |
| prestrobe_o | output | 1 | Pre-strobe control line |
| armed_o | output | 3 | Arm bits {pre-strobe, strobe, shutter} |

## Verification
The assertions assume the trigger lines may be asynchronous, but they do not assume any pulse width. They assume that a write setting an arm bit can land in the same cycle as that channel's done pulse, so the arm-clear property excludes that case. The stimulus holds each trigger level for several cycles so that every edge passes the synchronizer. It draws delays and durations from small random ranges so that a whole pulse fits in the capture window. It rewrites the control word without arm bits whenever only the divisor or the polarity changes.

// File: rtl/fst_pkg.sv
package fst_pkg;
  localparam int NUM_CH   = 3;
  localparam int NUM_SRC  = 4;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int DIV_W    = 9;
  localparam int FRM_W    = 6;
  localparam int DLY_W    = 25;
  localparam int DUR_W    = 24;
  localparam int ADDR_W   = 4;
  localparam int CFG_W    = DLY_W;

  // control word field positions
  localparam int DIV_LSB  = 0;
  localparam int SEL_LSB  = DIV_LSB + DIV_W;
  localparam int POLS_BIT = SEL_LSB + SEL_W;
  localparam int POLF_BIT = POLS_BIT + 1;
  localparam int GDIR_BIT = POLF_BIT + 1;
  localparam int GEN_BIT  = GDIR_BIT + 1;
  localparam int ARM_LSB  = GEN_BIT + 1;

  typedef enum logic [1:0] {
    CH_IDLE,
    CH_WAIT_FRAMES,
    CH_WAIT_DELAY,
    CH_ACTIVE
  } ch_state_t;

  typedef struct packed {
    logic [FRM_W-1:0] frames;
    logic [DLY_W-1:0] delay;
    logic [DUR_W-1:0] dur;
  } ch_cfg_t;
endpackage

// File: rtl/fst_prescaler.sv
module fst_prescaler #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (div_i != '0) && (cnt_q >= div_i - 1'b1);
  assign tick_o = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (div_i == '0)    cnt_q <= '0;
    else if (wrap)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R2: with a steady divisor above one, ticks never come back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i > 1) |=> (!tick_o || div_i != $past(div_i)));
endmodule

// File: rtl/fst_trigger_sync.sv
module fst_trigger_sync #(
  parameter int NUM_SRC = 4,
  localparam int SEL_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lines_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               edge_o
);
  logic [NUM_SRC-1:0] meta_q, sync_q;
  logic               prev_q;
  logic               picked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= lines_i;
      sync_q <= meta_q;
    end
  end

  assign picked = sync_q[sel_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= picked;
  end

  assign edge_o = picked & ~prev_q;

  // R1: two detected edges are always separated by at least one low sample
  assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o);
endmodule

// File: rtl/fst_channel.sv
module fst_channel
  import fst_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick_i,
  input  logic    frame_edge_i,
  input  logic    arm_i,
  input  ch_cfg_t cfg_i,
  output logic    active_o,
  output logic    done_o
);
  ch_state_t        st_q;
  logic [FRM_W-1:0] frm_q;
  logic [DLY_W-1:0] rem_q;
  logic [DUR_W-1:0] dur_q;
  logic             dly_go;
  logic             act_end;

  assign dly_go  = (st_q == CH_WAIT_DELAY) && ((rem_q == '0) || (tick_i && rem_q == 1));
  assign act_end = (st_q == CH_ACTIVE) && tick_i && (rem_q == 1);
  assign done_o  = act_end || (dly_go && dur_q == '0);
  assign active_o = (st_q == CH_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CH_IDLE;
      frm_q <= '0;
      rem_q <= '0;
      dur_q <= '0;
    end else begin
      unique case (st_q)
        CH_IDLE: if (arm_i) begin
          frm_q <= cfg_i.frames;
          rem_q <= cfg_i.delay;
          dur_q <= cfg_i.dur;
          st_q  <= (cfg_i.frames != '0) ? CH_WAIT_FRAMES : CH_WAIT_DELAY;
        end
        CH_WAIT_FRAMES: if (frame_edge_i) begin
          if (frm_q == 1) st_q <= CH_WAIT_DELAY;
          frm_q <= frm_q - 1'b1;
        end
        CH_WAIT_DELAY: begin
          if (dly_go) begin
            rem_q <= DLY_W'(dur_q);
            st_q  <= (dur_q == '0) ? CH_IDLE : CH_ACTIVE;
          end else if (tick_i) begin
            rem_q <= rem_q - 1'b1;
          end
        end
        CH_ACTIVE: begin
          if (act_end)     st_q  <= CH_IDLE;
          else if (tick_i) rem_q <= rem_q - 1'b1;
        end
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  // R2: without a tick an active pulse neither ends nor counts
  assert_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_ACTIVE && !tick_i) |=> (st_q == CH_ACTIVE && $stable(rem_q)));
  // R3: the frame wait only advances on a frame edge
  assert_frames_need_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_WAIT_FRAMES && !frame_edge_i) |=> (st_q == CH_WAIT_FRAMES && $stable(frm_q)));
  // R10: a zero duration never reaches the active state
  assert_zero_dur_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CH_WAIT_DELAY && dur_q == '0) |=> (st_q != CH_ACTIVE));
  // R11: captured settings stay fixed while the channel is running
  assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != CH_IDLE && $past(st_q) != CH_IDLE) |-> $stable(dur_q));
endmodule

// File: rtl/flash_shutter_timer.sv
module flash_shutter_timer
  import fst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] frame_start_i,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic               shutter_o,
  output logic               strobe_o,
  output logic               prestrobe_o,
  output logic [NUM_CH-1:0]  armed_o
);
  logic [DIV_W-1:0]  div_q;
  logic [SEL_W-1:0]  sel_q;
  logic              pol_shut_q, pol_flash_q;
  ch_cfg_t           cfg_q [NUM_CH];
  logic [NUM_CH-1:0] arm_q, arm_set, done, active, pol, line;
  logic              tick, frame_edge, ctrl_wr;

  assign ctrl_wr = cfg_we_i && (cfg_addr_i == '0);

  // control word: global-reset bits are accepted and discarded
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q       <= '0;
      sel_q       <= '0;
      pol_shut_q  <= 1'b0;
      pol_flash_q <= 1'b0;
    end else if (ctrl_wr) begin
      div_q       <= cfg_wdata_i[DIV_LSB +: DIV_W];
      sel_q       <= cfg_wdata_i[SEL_LSB +: SEL_W];
      pol_shut_q  <= cfg_wdata_i[POLS_BIT];
      pol_flash_q <= cfg_wdata_i[POLF_BIT];
    end
  end

  fst_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_i(div_q), .tick_o(tick)
  );

  fst_trigger_sync #(.NUM_SRC(NUM_SRC)) u_trig (
    .clk(clk), .rst_n(rst_n), .lines_i(frame_start_i), .sel_i(sel_q), .edge_o(frame_edge)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(4 * (i + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (cfg_we_i) begin
        if (cfg_addr_i == BASE)      cfg_q[i].frames <= cfg_wdata_i[FRM_W-1:0];
        if (cfg_addr_i == BASE + 1)  cfg_q[i].delay  <= cfg_wdata_i[DLY_W-1:0];
        if (cfg_addr_i == BASE + 2)  cfg_q[i].dur    <= cfg_wdata_i[DUR_W-1:0];
      end
    end

    assign arm_set[i] = ctrl_wr && cfg_wdata_i[ARM_LSB + i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q[i] <= 1'b0;
      else        arm_q[i] <= (arm_q[i] && !done[i]) || arm_set[i];
    end

    fst_channel u_chan (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .frame_edge_i(frame_edge),
      .arm_i(arm_q[i]), .cfg_i(cfg_q[i]), .active_o(active[i]), .done_o(done[i])
    );

    assign pol[i]  = (i == 0) ? pol_shut_q : pol_flash_q;
    assign line[i] = active[i] ? pol[i] : ~pol[i];

    // R6: a finished pulse drops the arm bit unless re-armed in that cycle
    assert_arm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done[i] && !arm_set[i]) |=> !arm_q[i]);
    // R8: a control write without this arm bit never arms the channel
    assert_no_spurious_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !cfg_wdata_i[ARM_LSB + i] && !arm_q[i]) |=> !arm_q[i]);
    // R9: an unarmed line rests at its inactive level
    assert_idle_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_q[i] |-> (line[i] == ~pol[i]));
  end

  assign shutter_o   = line[0];
  assign strobe_o    = line[1];
  assign prestrobe_o = line[2];
  assign armed_o     = arm_q;
endmodule

// File: tb/flash_shutter_timer_tb.sv
module flash_shutter_timer_tb;
  localparam int CAP = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  frame_start = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [24:0] cfg_wdata = '0;
  logic        shutter, strobe, prestrobe;
  logic [2:0]  armed;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  logic [8:0] div_v = 9'd1;
  logic [1:0] sel_v = 2'd0;
  logic       pol_s = 1'b1, pol_f = 1'b0;
  logic       cap [3][CAP];

  always #2.5 clk = ~clk;

  flash_shutter_timer u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .shutter_o(shutter),
    .strobe_o(strobe), .prestrobe_o(prestrobe), .armed_o(armed)
  );

  function automatic logic [2:0] outs();
    return {prestrobe, strobe, shutter};
  endfunction
  function automatic logic polof(int ch);
    return (ch == 0) ? pol_s : pol_f;
  endfunction
  function automatic int exp_rise(int d);
    return (d == 0) ? 2 : d + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask
  task automatic chk_range(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [24:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask
  task automatic wr_ctrl(logic [2:0] arm, logic gen = 1'b0, logic gdir = 1'b0);
    wr(4'd0, {7'd0, arm, gen, gdir, pol_f, pol_s, sel_v, div_v});
  endtask
  task automatic set_ch(int ch, int f, int d, int n);
    wr(4'((ch + 1) * 4), 25'(f));
    wr(4'((ch + 1) * 4 + 1), 25'(d));
    wr(4'((ch + 1) * 4 + 2), 25'(n));
  endtask
  // samples start at the negedge that ends the arming write
  task automatic capture();
    for (int i = 0; i < CAP; i++) begin
      if (i > 0) @(negedge clk);
      for (int c = 0; c < 3; c++) cap[c][i] = (outs() >> c) & 1'b1;
    end
  endtask
  function automatic int first_rise(int ch);
    for (int i = 0; i < CAP; i++) if (cap[ch][i] == polof(ch)) return i;
    return -1;
  endfunction
  function automatic int width(int ch);
    int w = 0;
    for (int i = 0; i < CAP; i++) if (cap[ch][i] == polof(ch)) w++;
    return w;
  endfunction
  task automatic pulse_line(int k);
    @(negedge clk); frame_start[k] = 1'b1;
    repeat (4) @(negedge clk);
    frame_start[k] = 1'b0;
    repeat (4) @(negedge clk);
  endtask
  task automatic check_idle(string req, int ch, int exp_arm);
    chk({req, " level"}, int'((outs() >> ch) & 1'b1), int'(~polof(ch) & 1'b1));
    chk({req, " arm"}, int'(armed[ch]), exp_arm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    // reset state: polarities 0 -> active-low idle = 1 (R9, R7)
    chk("R9 reset outs", int'(outs()), 7);
    chk("R6 reset armed", int'(armed), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: zero delay, width 1, shutter (R4, R5)
    wr_ctrl(3'b000);
    set_ch(0, 0, 0, 1);
    wr_ctrl(3'b001);
    chk("R6 armed after write", int'(armed[0]), 1);
    capture();
    chk("R4 rise d0", first_rise(0), exp_rise(0));
    chk("R5 width 1", width(0), 1);
    chk("R6 self clear", int'(armed[0]), 0);

    // random: delay/duration/polarity/channel (R4 R5 R6 R7)
    for (int it = 0; it < 24; it++) begin
      int ch = $urandom_range(2, 0);
      int d  = $urandom_range(30, 0);
      int n  = $urandom_range(30, 1);
      pol_s = 1'($urandom_range(1, 0));
      pol_f = 1'($urandom_range(1, 0));
      wr_ctrl(3'b000);
      check_idle("R7 idle", ch, 0);
      set_ch(ch, 0, d, n);
      wr_ctrl(3'(1 << ch));
      capture();
      chk("R4 rise", first_rise(ch), exp_rise(d));
      chk("R5 width", width(ch), n);
      chk("R6 clear", int'(armed[ch]), 0);
      chk("R7 first sample idle", int'(cap[ch][0]), int'(~polof(ch) & 1'b1));
    end

    // R10: zero duration
    pol_s = 1'b1; pol_f = 1'b1;
    wr_ctrl(3'b000);
    set_ch(1, 0, 2, 0);
    wr_ctrl(3'b010);
    capture();
    chk("R10 no pulse", width(1), 0);
    chk("R10 arm cleared", int'(armed[1]), 0);

    // R11: change duration while armed
    set_ch(2, 0, 12, 3);
    wr_ctrl(3'b100);
    wr(4'd14, 25'd9);
    capture();
    chk("R11 old duration used", width(2), 3);
    wr_ctrl(3'b100);
    capture();
    chk("R11 new duration next arm", width(2), 9);

    // R12: two channels armed together
    set_ch(0, 0, 4, 2);
    set_ch(1, 0, 20, 5);
    wr_ctrl(3'b011);
    capture();
    chk("R12 shutter rise", first_rise(0), exp_rise(4));
    chk("R12 shutter width", width(0), 2);
    chk("R12 strobe rise", first_rise(1), exp_rise(20));
    chk("R12 strobe width", width(1), 5);

    // R2: divisor 0 freezes, divisor 4 stretches
    div_v = 9'd0;
    wr_ctrl(3'b000);
    set_ch(1, 0, 3, 2);
    wr_ctrl(3'b010);
    repeat (60) @(negedge clk);
    check_idle("R2 frozen", 1, 1);
    div_v = 9'd1;
    wr_ctrl(3'b000);
    capture();
    chk("R2 resumes width", width(1), 2);
    chk("R2 resumes clear", int'(armed[1]), 0);
    div_v = 9'd4;
    wr_ctrl(3'b000);
    set_ch(1, 0, 0, 5);
    wr_ctrl(3'b010);
    capture();
    chk_range("R5 width div4", width(1), 17, 20);
    chk("R2 div4 clear", int'(armed[1]), 0);

    // R3 / R1: frame counting on selected line 2
    div_v = 9'd1; sel_v = 2'd2;
    wr_ctrl(3'b000);
    set_ch(0, 2, 1, 4);
    wr_ctrl(3'b001);
    repeat (20) @(negedge clk);
    check_idle("R3 waiting", 0, 1);
    pulse_line(1); pulse_line(3); pulse_line(0);
    repeat (20) @(negedge clk);
    check_idle("R1 other lines ignored", 0, 1);
    pulse_line(2);
    repeat (20) @(negedge clk);
    check_idle("R3 one of two frames", 0, 1);
    @(negedge clk); frame_start[2] = 1'b1;
    capture();
    frame_start[2] = 1'b0;
    chk("R3 pulse after second frame", width(0), 4);
    chk("R3 clear", int'(armed[0]), 0);

    // R3: zero frames ignores triggers entirely
    set_ch(0, 0, 1, 2);
    wr_ctrl(3'b001);
    capture();
    chk("R3 zero frames rise", first_rise(0), exp_rise(1));

    // R8: global reset enable/direction writes start nothing
    set_ch(0, 0, 0, 3); set_ch(1, 0, 0, 3); set_ch(2, 0, 0, 3);
    wr_ctrl(3'b000, 1'b1, 1'b0);
    capture();
    chk("R8 no shutter", width(0), 0);
    chk("R8 no strobe", width(1), 0);
    chk("R8 no prestrobe", width(2), 0);
    chk("R8 not armed", int'(armed), 0);
    wr_ctrl(3'b000, 1'b1, 1'b1);
    capture();
    chk("R8 dir out no arm", int'(armed), 0);
    chk("R9 idle levels", int'(outs()), int'({~pol_f, ~pol_f, ~pol_s} & 3'b111));

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule